// File: doc/BRIEF.md
# Drive Geometry Calculator

This unit turns the total number of sectors on a drive into the legacy cylinder, head and sector-per-track triple that belongs in a drive identification record. A single start pulse hands it a count. Some time later a one-cycle done pulse marks that the three geometry outputs hold the result. The outputs then stay frozen until the next result is produced.

Very large counts saturate to a fixed maximum geometry. Zero is answered at once with an all-zero triple. Every other count is clamped in two steps. Sectors per track is limited to the maximum and heads to its maximum. The cylinder count is then the truncated quotient of the count by heads times sectors. Both divisions run on one shared restoring divider that retires one quotient bit per clock, so there is no combinational divide in the path. The saturation and zero cases skip the divider and finish in the cycle after start.

Top module: `chs_geom_calc`

## Requirements
- R1: When start is accepted with a count of at least 16383*16*63 (16514064), done is high in the next cycle, and cylinders reads 16383, heads 16 and sectors 63.
- R2: For a nonzero count below that limit, sectors per track is 63 if the count is at least 63, and the count itself otherwise.
- R3: For a nonzero count below that limit, heads is the count divided by sectors per track, truncated, and limited to 16.
- R4: For a nonzero count below that limit, cylinders is the count divided by (heads times sectors per track), truncated.
- R5: When start is accepted with a count of zero, done is high in the next cycle and all three outputs read zero.
- R6: Done is high for exactly one cycle per accepted start.
- R7: A start raised while a computation is in progress has no effect. The running computation completes with the result of its own count, and no extra done follows.
- R8: After reset, done and all outputs are zero. The outputs change only in the cycle in which done rises, whatever the count input does in between.
- R9: A start raised in the same cycle as a done pulse is accepted and starts a new computation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a computation on count_i (accepted only when idle) |
| count_i | input | 32 | Total sector count |
| done_o | output | 1 | One-cycle pulse: result is valid |
| cyl_o | output | 16 | Cylinders |
| heads_o | output | 8 | Heads |
| sect_o | output | 8 | Sectors per track |

## Verification
Result delivery and command acceptance can fall in the same cycle. The unit returns to idle on the edge that raises done, so a start held during the done cycle must be taken. The bench waits for the done of a long division, raises a new start with a different count in that very cycle, and then checks two things. The first triple must be on the outputs while done is high, and the second count must produce its own correct triple after exactly one further done pulse. A second overlap, a start during a busy division, is judged by the first count's result and by the absence of any further done.

// File: rtl/chs_geom_pkg.sv
package chs_geom_pkg;

   typedef enum logic [1:0] {
      ST_IDLE     = 2'd0,
      ST_DIV_SECT = 2'd1,
      ST_DIV_CYL  = 2'd2
   } geom_state_e;

endpackage

// File: rtl/geom_divider.sv
module geom_divider #(
   parameter int W = 32
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         go_i,
   input  logic [W-1:0] dividend_i,
   input  logic [W-1:0] divisor_i,
   output logic [W-1:0] quot_o,
   output logic         done_o
);
   localparam int CW = $clog2(W + 1);

   logic [W-1:0]  rem_q;
   logic [W-1:0]  quo_q;
   logic [CW-1:0] cnt_q;
   logic          run_q;
   logic [W:0]    shifted;
   logic          fits;
   logic [W:0]    diff;
   logic [W-1:0]  rem_d;

   // one restoring step: bring in the next dividend bit, subtract if it fits
   assign shifted = {rem_q, quo_q[W-1]};
   assign fits    = (shifted >= {1'b0, divisor_i});
   assign diff    = shifted - {1'b0, divisor_i};
   assign rem_d   = fits ? diff[W-1:0] : shifted[W-1:0];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rem_q  <= '0;
         quo_q  <= '0;
         cnt_q  <= '0;
         run_q  <= 1'b0;
         done_o <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (go_i) begin
            rem_q <= '0;
            quo_q <= dividend_i;
            cnt_q <= CW'(W);
            run_q <= 1'b1;
         end else if (run_q) begin
            rem_q <= rem_d;
            quo_q <= {quo_q[W-2:0], fits};
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CW'(1)) begin
               run_q  <= 1'b0;
               done_o <= 1'b1;
            end
         end
      end
   end

   assign quot_o = quo_q;

endmodule

// File: rtl/geom_limits.sv
module geom_limits #(
   parameter int CNT_W    = 32,
   parameter int HEAD_W   = 8,
   parameter int SECT_W   = 8,
   parameter int MAX_CYL  = 16383,
   parameter int MAX_HEAD = 16,
   parameter int MAX_SECT = 63
) (
   input  logic [CNT_W-1:0]  count_i,
   input  logic [CNT_W-1:0]  quot_i,
   output logic              is_zero_o,
   output logic              is_sat_o,
   output logic [SECT_W-1:0] sect_o,
   output logic [HEAD_W-1:0] heads_o
);
   localparam longint unsigned THRESH_L =
      longint'(MAX_CYL) * longint'(MAX_HEAD) * longint'(MAX_SECT);

   assign is_zero_o = (count_i == '0);

   generate
      if ((THRESH_L >> CNT_W) != 0) begin : g_no_sat
         // limit exceeds the count range: saturation can never occur
         assign is_sat_o = 1'b0;
      end else begin : g_sat
         assign is_sat_o = (64'(count_i) >= THRESH_L);
      end
   endgenerate

   assign sect_o  = (count_i >= CNT_W'(MAX_SECT)) ? SECT_W'(MAX_SECT) : SECT_W'(count_i);
   assign heads_o = (quot_i  >= CNT_W'(MAX_HEAD)) ? HEAD_W'(MAX_HEAD) : HEAD_W'(quot_i);

endmodule

// File: rtl/chs_geom_calc.sv
module chs_geom_calc
   import chs_geom_pkg::*;
#(
   parameter int CNT_W    = 32,
   parameter int CYL_W    = 16,
   parameter int HEAD_W   = 8,
   parameter int SECT_W   = 8,
   parameter int MAX_CYL  = 16383,
   parameter int MAX_HEAD = 16,
   parameter int MAX_SECT = 63
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic [CNT_W-1:0]  count_i,
   output logic              done_o,
   output logic [CYL_W-1:0]  cyl_o,
   output logic [HEAD_W-1:0] heads_o,
   output logic [SECT_W-1:0] sect_o
);
   generate
      if (MAX_CYL >= (1 << CYL_W)) begin : g_err_cyl
         $error("MAX_CYL does not fit in CYL_W");
      end
      if (MAX_HEAD >= (1 << HEAD_W)) begin : g_err_head
         $error("MAX_HEAD does not fit in HEAD_W");
      end
      if (MAX_SECT >= (1 << SECT_W)) begin : g_err_sect
         $error("MAX_SECT does not fit in SECT_W");
      end
      if (HEAD_W + SECT_W > CNT_W || CNT_W > 63) begin : g_err_cnt
         $error("CNT_W out of range");
      end
   endgenerate

   geom_state_e       state_q;
   logic              busy;
   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  den_q;
   logic              div_go_q;
   logic              div_done;
   logic [CNT_W-1:0]  quo;
   logic [SECT_W-1:0] sect_q;
   logic [HEAD_W-1:0] heads_q;
   logic              is_zero;
   logic              is_sat;
   logic [SECT_W-1:0] sect_clamp;
   logic [HEAD_W-1:0] heads_clamp;

   assign busy = (state_q != ST_IDLE);

   geom_limits #(
      .CNT_W(CNT_W), .HEAD_W(HEAD_W), .SECT_W(SECT_W),
      .MAX_CYL(MAX_CYL), .MAX_HEAD(MAX_HEAD), .MAX_SECT(MAX_SECT)
   ) u_limits (
      .count_i  (count_i),
      .quot_i   (quo),
      .is_zero_o(is_zero),
      .is_sat_o (is_sat),
      .sect_o   (sect_clamp),
      .heads_o  (heads_clamp)
   );

   geom_divider #(.W(CNT_W)) u_div (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .go_i      (div_go_q),
      .dividend_i(cnt_q),
      .divisor_i (den_q),
      .quot_o    (quo),
      .done_o    (div_done)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q  <= ST_IDLE;
         cnt_q    <= '0;
         den_q    <= '0;
         div_go_q <= 1'b0;
         sect_q   <= '0;
         heads_q  <= '0;
         done_o   <= 1'b0;
         cyl_o    <= '0;
         heads_o  <= '0;
         sect_o   <= '0;
      end else begin
         div_go_q <= 1'b0;
         done_o   <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  cnt_q <= count_i;
                  if (is_zero) begin
                     cyl_o   <= '0;
                     heads_o <= '0;
                     sect_o  <= '0;
                     done_o  <= 1'b1;
                  end else if (is_sat) begin
                     cyl_o   <= CYL_W'(MAX_CYL);
                     heads_o <= HEAD_W'(MAX_HEAD);
                     sect_o  <= SECT_W'(MAX_SECT);
                     done_o  <= 1'b1;
                  end else begin
                     sect_q   <= sect_clamp;
                     den_q    <= CNT_W'(sect_clamp);
                     div_go_q <= 1'b1;
                     state_q  <= ST_DIV_SECT;
                  end
               end
            end
            ST_DIV_SECT: begin
               if (div_done) begin
                  heads_q  <= heads_clamp;
                  den_q    <= CNT_W'(heads_clamp) * CNT_W'(sect_q);
                  div_go_q <= 1'b1;
                  state_q  <= ST_DIV_CYL;
               end
            end
            ST_DIV_CYL: begin
               if (div_done) begin
                  cyl_o   <= CYL_W'(quo);
                  heads_o <= heads_q;
                  sect_o  <= sect_q;
                  done_o  <= 1'b1;
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/chs_geom_chk.sv
module chs_geom_chk #(
   parameter int CNT_W    = 32,
   parameter int CYL_W    = 16,
   parameter int HEAD_W   = 8,
   parameter int SECT_W   = 8,
   parameter int MAX_CYL  = 16383,
   parameter int MAX_HEAD = 16,
   parameter int MAX_SECT = 63
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              start_i,
   input logic [CNT_W-1:0]  count_i,
   input logic              done_o,
   input logic [CYL_W-1:0]  cyl_o,
   input logic [HEAD_W-1:0] heads_o,
   input logic [SECT_W-1:0] sect_o,
   input logic              busy_i,
   input logic [CNT_W-1:0]  cnt_lat_i
);
   localparam longint unsigned THRESH_L =
      longint'(MAX_CYL) * longint'(MAX_HEAD) * longint'(MAX_SECT);

   logic [63:0] prod;
   assign prod = 64'(cyl_o) * 64'(heads_o) * 64'(sect_o);

   assert_sat_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_i && !busy_i && 64'(count_i) >= THRESH_L) |=>
         (done_o && cyl_o == CYL_W'(MAX_CYL) && heads_o == HEAD_W'(MAX_HEAD)
          && sect_o == SECT_W'(MAX_SECT)));

   assert_bounds_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> (sect_o <= SECT_W'(MAX_SECT) && heads_o <= HEAD_W'(MAX_HEAD)));

   assert_product_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> (prod <= 64'(cnt_lat_i)));

   assert_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_i && !busy_i && count_i == '0) |=>
         (done_o && cyl_o == '0 && heads_o == '0 && sect_o == '0));

   assert_done_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o);

   assert_ignore_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_i && busy_i) |=> $stable(cnt_lat_i));

   assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !done_o |-> ($stable(cyl_o) && $stable(heads_o) && $stable(sect_o)));

endmodule

bind chs_geom_calc chs_geom_chk #(
   .CNT_W(CNT_W), .CYL_W(CYL_W), .HEAD_W(HEAD_W), .SECT_W(SECT_W),
   .MAX_CYL(MAX_CYL), .MAX_HEAD(MAX_HEAD), .MAX_SECT(MAX_SECT)
) u_chk (
   .clk_i    (clk_i),
   .rst_ni   (rst_ni),
   .start_i  (start_i),
   .count_i  (count_i),
   .done_o   (done_o),
   .cyl_o    (cyl_o),
   .heads_o  (heads_o),
   .sect_o   (sect_o),
   .busy_i   (busy),
   .cnt_lat_i(cnt_q)
);

// File: tb/test_chs_geom_calc.sv
module test_chs_geom_calc;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] count = '0;
   logic        done_o;
   logic [15:0] cyl_o;
   logic [7:0]  heads_o;
   logic [7:0]  sect_o;

   int n_chk = 0;
   int n_fail = 0;

   localparam longint unsigned LIMIT = 64'd16514064;

   always #10 clk = ~clk;

   chs_geom_calc i_chs_geom_calc (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .count_i(count),
      .done_o(done_o), .cyl_o(cyl_o), .heads_o(heads_o), .sect_o(sect_o)
   );

   task automatic chk(input string req, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic void ref_geom(input logic [31:0] c, output int cy, output int h, output int s);
      longint unsigned cc = 64'(c);
      if (cc == 0) begin cy = 0; h = 0; s = 0; end
      else if (cc >= LIMIT) begin cy = 16383; h = 16; s = 63; end
      else begin
         s  = (cc >= 63) ? 63 : int'(cc);
         h  = ((cc / 64'(s)) >= 16) ? 16 : int'(cc / 64'(s));
         cy = int'(cc / 64'(h * s));
      end
   endfunction

   task automatic pulse_start(input logic [31:0] c);
      @(negedge clk);
      start = 1'b1;
      count = c;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done(output bit ok);
      ok = 1'b0;
      for (int i = 0; i < 400; i++) begin
         if (done_o) begin ok = 1'b1; break; end
         @(negedge clk);
      end
   endtask

   task automatic check_result(input logic [31:0] c, input string tag);
      int cy, h, s;
      ref_geom(c, cy, h, s);
      chk({tag, " R2 sectors"}, longint'(sect_o), longint'(s));
      chk({tag, " R3 heads"}, longint'(heads_o), longint'(h));
      chk({tag, " R4 cylinders"}, longint'(cyl_o), longint'(cy));
   endtask

   task automatic run_case(input logic [31:0] c, input string tag);
      bit ok;
      pulse_start(c);
      wait_done(ok);
      chk({tag, " done seen"}, longint'(ok), 1);
      check_result(c, tag);
      @(negedge clk);
      chk({tag, " R6 done drops"}, longint'(done_o), 0);
   endtask

   task automatic t_reset();
      chk("R8 reset done", longint'(done_o), 0);
      chk("R8 reset cyl", longint'(cyl_o), 0);
      chk("R8 reset heads", longint'(heads_o), 0);
      chk("R8 reset sect", longint'(sect_o), 0);
   endtask

   task automatic t_fast(input logic [31:0] c, input string tag);
      pulse_start(c);
      chk({tag, " done next cycle"}, longint'(done_o), 1);
      check_result(c, tag);
      @(negedge clk);
      chk({tag, " R6 done drops"}, longint'(done_o), 0);
   endtask

   task automatic t_ignore();
      bit ok;
      int extra = 0;
      pulse_start(32'd5000);
      repeat (5) @(negedge clk);
      pulse_start(32'd1);
      wait_done(ok);
      chk("R7 done seen", longint'(ok), 1);
      check_result(32'd5000, "R7 busy start ignored");
      @(negedge clk);
      for (int i = 0; i < 150; i++) begin
         if (done_o) extra++;
         @(negedge clk);
      end
      chk("R7 no extra done", longint'(extra), 0);
   endtask

   task automatic t_back_to_back();
      bit ok;
      pulse_start(32'd1000000);
      wait_done(ok);
      chk("R9 first done", longint'(ok), 1);
      start = 1'b1;
      count = 32'd1000;
      check_result(32'd1000000, "R9 first");
      @(negedge clk);
      start = 1'b0;
      chk("R6 single pulse at overlap", longint'(done_o), 0);
      wait_done(ok);
      chk("R9 second accepted", longint'(ok), 1);
      check_result(32'd1000, "R9 second");
      @(negedge clk);
   endtask

   task automatic t_hold();
      int cy, h, s;
      int changes = 0;
      ref_geom(32'd77777, cy, h, s);
      run_case(32'd77777, "hold setup");
      for (int i = 0; i < 20; i++) begin
         count = 32'(i * 911);
         @(negedge clk);
         if (done_o || cyl_o != 16'(cy) || heads_o != 8'(h) || sect_o != 8'(s)) changes++;
      end
      chk("R8 outputs hold without start", longint'(changes), 0);
   endtask

   initial begin
      #(200000 * 20);
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_fast(32'd0, "R5 zero");
      t_fast(32'd16514064, "R1 at limit");
      t_fast(32'hFFFF_FFFF, "R1 max count");
      run_case(32'd1, "R2 one");
      run_case(32'd62, "R2 below 63");
      run_case(32'd63, "R2 exactly 63");
      run_case(32'd64, "R2 above 63");
      run_case(32'd1007, "R3 heads 15");
      run_case(32'd1008, "R3 heads 16");
      run_case(32'd5000, "R4 mid");
      run_case(32'd1000000, "R4 large");
      run_case(32'd16514063, "R4 just below limit");
      t_fast(32'd0, "R5 zero again");
      t_ignore();
      t_back_to_back();
      t_hold();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule